// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Packed Status

This block is a purely combinational 8-bit datapath that performs addition and subtraction, each with or without an incoming carry, and the three bitwise operations AND, OR and XOR. Alongside the 8-bit result it produces a packed status byte. The status byte holds sign, zero, nibble carry, a shared parity-or-overflow bit, a subtract marker and the carry.

A surrounding execution stage drives the two operands, the stored carry and a 3-bit operation code. It captures the result and the status byte in its own registers. The nibble carry and the subtract marker are there for a later decimal-correction step, which is not part of this block. The adder is a 4-bit ripple stage for the low nibble with an explicit carry tap at bit 4. The high nibble uses either a second ripple stage or a carry-select pair, chosen by parameter.

Top module: `alu8_flag_gen`

## Requirements
- R1: The status byte places sign at bit 7, zero at bit 6, nibble carry at bit 4, parity/overflow at bit 2, subtract marker at bit 1 and carry at bit 0; bits 5 and 3 are always 0.
- R2: The sign bit equals bit 7 of the result for every operation.
- R3: The zero bit is 1 exactly when the 8-bit result is 0x00.
- R4: The subtract marker is 1 for the two subtract codes and 0 for every other code.
- R5: For additions the carry bit is the carry out of bit 7 of a + b (+ carry_i for code 1). For subtractions it is the borrow of a - b (- carry_i for code 3). carry_i has no effect on codes 0 and 2.
- R6: For additions the nibble carry bit is the carry out of bit 3. For subtractions it is the borrow into bit 4, counting the incoming borrow for code 3.
- R7: For arithmetic codes, bit 2 is 1 when the signed two's-complement result falls outside -128..127.
- R8: For logical codes, bit 2 is 1 when the result holds an even number of ones (zero ones counts as even).
- R9: AND returns a & b with nibble carry 1 and carry 0. OR and XOR return a | b and a ^ b with nibble carry 0 and carry 0.
- R10: Operation codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 also XOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (see R10) |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry or borrow, used only by codes 1 and 3 |
| result_o | output | 8 | Operation result |
| flags_o | output | 8 | Packed status byte (see R1) |

## Verification
The block holds no state, so a fault in the nibble tap, the carry chain or the carry-select mux shows up at once as a wrong result or status bit for the inputs that exercise that path. Nothing is hidden until a later cycle. A broken tap shows only on operand pairs that carry or borrow across bit 4. A wrong inversion on the subtract path shows as carry, nibble carry and overflow bits that are swapped in sense. The sweep therefore covers every first operand against a strided set of second operands that includes 0x00, 0x7F, 0x80 and 0xFF, with both carry values and all eight codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;

   // status byte bit positions
   localparam int unsigned ST_SIGN = 7;
   localparam int unsigned ST_ZERO = 6;
   localparam int unsigned ST_HALF = 4;
   localparam int unsigned ST_PV   = 2;
   localparam int unsigned ST_SUB  = 1;
   localparam int unsigned ST_CY   = 0;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADC  = 3'd1,
      OP_SUB  = 3'd2,
      OP_SBC  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_XOR  = 3'd6,
      OP_XOR2 = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic half;
      logic pv;
      logic sub;
      logic cy;
   } alu_stat_t;

endpackage

// File: rtl/alu8_nib_add.sv
module alu8_nib_add #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         c_i,
   output logic [W-1:0] s_o,
   output logic         c_o
);
   if (W < 1) begin : g_bad_w
      $error("alu8_nib_add: W must be at least 1");
   end

   logic [W:0] chain;
   assign chain[0] = c_i;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign s_o[i]     = x_i[i] ^ y_i[i] ^ chain[i];
      assign chain[i+1] = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
   end

   assign c_o = chain[W];
endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit #(
   parameter int unsigned W = 8
) (
   input  logic [1:0]   sel_i,
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] z_o
);
   always_comb begin
      unique case (sel_i)
         2'b00:   z_o = x_i & y_i;
         2'b01:   z_o = x_i | y_i;
         default: z_o = x_i ^ y_i;
      endcase
   end
endmodule

// File: rtl/alu8_stat_pack.sv
module alu8_stat_pack
   import alu8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  alu_stat_t    st_i,
   output logic [W-1:0] byte_o
);
   if (W != BYTE_W) begin : g_bad_w
      $error("alu8_stat_pack: status byte must be 8 bits wide");
   end

   always_comb begin
      byte_o          = '0;
      byte_o[ST_SIGN] = st_i.sign;
      byte_o[ST_ZERO] = st_i.zero;
      byte_o[ST_HALF] = st_i.half;
      byte_o[ST_PV]   = st_i.pv;
      byte_o[ST_SUB]  = st_i.sub;
      byte_o[ST_CY]   = st_i.cy;
   end
endmodule

// File: rtl/alu8_flag_gen.sv
module alu8_flag_gen
   import alu8_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDER_STYLE = 0   // 0: ripple, 1: carry-select high nibble
) (
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic [DATA_W-1:0] flags_o
);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned MSB    = DATA_W - 1;

   if (DATA_W != BYTE_W) begin : g_bad_w
      $error("alu8_flag_gen: DATA_W must be 8");
   end
   if (HALF_W != NIB_W) begin : g_bad_nib
      $error("alu8_flag_gen: nibble width mismatch");
   end
   if (ADDER_STYLE > 1) begin : g_bad_style
      $error("alu8_flag_gen: ADDER_STYLE must be 0 or 1");
   end

   // operation class decode
   logic is_logic, is_sub, use_cin;
   assign is_logic = op_i[2];
   assign is_sub   = op_i[1] & ~op_i[2];
   assign use_cin  = op_i[0] & ~op_i[2];

   // subtraction as a + ~b + ~borrow
   logic [DATA_W-1:0] b_eff;
   logic              cin_eff;
   assign b_eff   = is_sub ? ~b_i : b_i;
   assign cin_eff = (use_cin & carry_i) ^ is_sub;

   logic [HALF_W-1:0] sum_lo, sum_hi;
   logic              c_nib, c_top;

   alu8_nib_add #(.W(HALF_W)) u_lo (
      .x_i(a_i[HALF_W-1:0]), .y_i(b_eff[HALF_W-1:0]), .c_i(cin_eff),
      .s_o(sum_lo), .c_o(c_nib)
   );

   if (ADDER_STYLE == 0) begin : g_ripple
      alu8_nib_add #(.W(HALF_W)) u_hi (
         .x_i(a_i[DATA_W-1:HALF_W]), .y_i(b_eff[DATA_W-1:HALF_W]), .c_i(c_nib),
         .s_o(sum_hi), .c_o(c_top)
      );
   end else begin : g_csel
      logic [HALF_W-1:0] s0, s1;
      logic              co0, co1;
      alu8_nib_add #(.W(HALF_W)) u_hi0 (
         .x_i(a_i[DATA_W-1:HALF_W]), .y_i(b_eff[DATA_W-1:HALF_W]), .c_i(1'b0),
         .s_o(s0), .c_o(co0)
      );
      alu8_nib_add #(.W(HALF_W)) u_hi1 (
         .x_i(a_i[DATA_W-1:HALF_W]), .y_i(b_eff[DATA_W-1:HALF_W]), .c_i(1'b1),
         .s_o(s1), .c_o(co1)
      );
      assign sum_hi = c_nib ? s1 : s0;
      assign c_top  = c_nib ? co1 : co0;
   end

   logic [DATA_W-1:0] arith_res, logic_res, res;
   assign arith_res = {sum_hi, sum_lo};

   alu8_logic_unit #(.W(DATA_W)) u_logic (
      .sel_i(op_i[1:0]), .x_i(a_i), .y_i(b_i), .z_o(logic_res)
   );

   assign res = is_logic ? logic_res : arith_res;

   logic ovf;
   assign ovf = (a_i[MSB] == b_eff[MSB]) && (arith_res[MSB] != a_i[MSB]);

   alu_stat_t st;
   always_comb begin
      st.sign = res[MSB];
      st.zero = (res == '0);
      st.sub  = is_sub;
      if (is_logic) begin
         st.half = (op_i[1:0] == 2'b00);
         st.cy   = 1'b0;
         st.pv   = ~^res;
      end else begin
         st.half = c_nib ^ is_sub;
         st.cy   = c_top ^ is_sub;
         st.pv   = ovf;
      end
   end

   alu8_stat_pack #(.W(DATA_W)) u_pack (.st_i(st), .byte_o(flags_o));

   assign result_o = res;

   // port-level checks
   always_comb begin
      a_r1_spare_bits: assert (flags_o[5] == 1'b0 && flags_o[3] == 1'b0)
         else $error("R1 spare status bits not zero");
      a_r2_sign: assert (flags_o[ST_SIGN] == result_o[MSB])
         else $error("R2 sign bit disagrees with result");
      a_r3_zero: assert (flags_o[ST_ZERO] == (result_o == '0))
         else $error("R3 zero bit disagrees with result");
      if (op_i == OP_ADD) begin
         a_r5_add_carry: assert (flags_o[ST_CY] == (result_o < a_i))
            else $error("R5 add carry wrong");
      end
      if (op_i == OP_SUB) begin
         a_r5_sub_borrow: assert (flags_o[ST_CY] == (a_i < b_i))
            else $error("R5 subtract borrow wrong");
         a_r3_sub_equal: assert (flags_o[ST_ZERO] == (a_i == b_i))
            else $error("R3 subtract zero wrong");
      end
      if (op_i[2]) begin
         a_r9_logic_no_carry: assert (flags_o[ST_CY] == 1'b0 && flags_o[ST_SUB] == 1'b0)
            else $error("R9 logical op left carry or subtract set");
      end
   end
endmodule

// File: tb/tb_alu8_flag_gen.sv
module tb_alu8_flag_gen;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   logic [2:0] op;
   logic [7:0] a, b;
   logic       cin;
   logic [7:0] res, flg;

   alu8_flag_gen dut (
      .op_i(op), .a_i(a), .b_i(b), .carry_i(cin),
      .result_o(res), .flags_o(flg)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         if (n_fail <= 20)
            $display("FAIL %s %s op=%0d a=%02h b=%02h cin=%0d actual=%0h expected=%0h",
                     req, what, op, a, b, cin, act, exp);
      end
   endtask

   task automatic run_vec(input int o, input int x, input int y, input int c);
      int full, nib, sres, r, e_s, e_z, e_h, e_pv, e_n, e_c, ci;
      bit arith;
      op = 3'(o); a = 8'(x); b = 8'(y); cin = c[0];
      #1;
      arith = (o < 4);
      ci    = (o == 1 || o == 3) ? c : 0;
      e_n   = (o == 2 || o == 3) ? 1 : 0;
      if (o == 0 || o == 1) begin
         full = x + y + ci;
         nib  = (x & 15) + (y & 15) + ci;
         sres = $signed(8'(x)) + $signed(8'(y)) + ci;
         e_c  = (full > 255) ? 1 : 0;
         e_h  = (nib > 15) ? 1 : 0;
      end else if (o == 2 || o == 3) begin
         full = x - y - ci;
         nib  = (x & 15) - (y & 15) - ci;
         sres = $signed(8'(x)) - $signed(8'(y)) - ci;
         e_c  = (full < 0) ? 1 : 0;
         e_h  = (nib < 0) ? 1 : 0;
      end else begin
         full = (o == 4) ? (x & y) : (o == 5) ? (x | y) : (x ^ y);
         sres = 0;
         e_c  = 0;
         e_h  = (o == 4) ? 1 : 0;
      end
      r    = full & 255;
      e_s  = (r >> 7) & 1;
      e_z  = (r == 0) ? 1 : 0;
      e_pv = arith ? ((sres > 127 || sres < -128) ? 1 : 0)
                   : (($countones(8'(r)) % 2 == 0) ? 1 : 0);
      chk(arith ? "R5" : "R9", "result R10", int'(res), r);
      chk("R1", "spare bits", int'({flg[5], flg[3]}), 0);
      chk("R2", "sign", int'(flg[7]), e_s);
      chk("R3", "zero", int'(flg[6]), e_z);
      chk("R4", "subtract marker", int'(flg[1]), e_n);
      chk(arith ? "R6" : "R9", "nibble carry", int'(flg[4]), e_h);
      chk(arith ? "R7" : "R8", "parity/overflow", int'(flg[2]), e_pv);
      chk(arith ? "R5" : "R9", "carry", int'(flg[0]), e_c);
   endtask

   initial begin
      op = '0; a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // state with all inputs at zero after reset: add 0+0 -> zero set, rest clear
      chk("R3", "idle flags", int'(flg), 8'h40);
      chk("R1", "idle result", int'(res), 0);
      rst = 1'b0;
      // directed corners
      run_vec(0, 8'h7F, 8'h01, 0);   // R7 overflow, R6 nibble carry
      run_vec(1, 8'hFF, 8'h00, 1);   // R5 carry with carry-in, R3 zero
      run_vec(0, 8'hFF, 8'h00, 1);   // R5 carry_i ignored for add
      run_vec(2, 8'h80, 8'h01, 1);   // R5 carry_i ignored for sub, R7
      run_vec(3, 8'h10, 8'h00, 1);   // R6 borrow into bit 4 from incoming borrow
      run_vec(4, 8'h00, 8'hFF, 0);   // R9 AND half set, R8 parity of zero
      run_vec(7, 8'hA5, 8'h0F, 1);   // R10 code 7 acts as XOR
      // near-exhaustive sweep
      for (int o = 0; o < 8; o++)
         for (int x = 0; x < 256; x++)
            for (int bi = 0; bi < 64; bi++)
               for (int c = 0; c < 2; c++)
                  run_vec(o, x, bi * 4 + (bi % 4), c);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int cyc = 0; cyc < 190000; cyc++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule